// File: doc/BRIEF.md
# Composite Video Line Timing Generator

This block produces the line and frame timing for a monochrome, non-interlaced composite picture, together with its serialized pixel stream. A free-running horizontal counter starts a new line every `LINE_CLKS` clocks, and a vertical counter steps through `FRAME_LINES` lines per frame. Every line opens with a sync pulse. A small line-kind state machine settles the pulse width at line start. Ordinary lines get a short horizontal pulse. A run of vertical-sync lines holds sync for nearly the whole line and leaves a short gap before the line ends.

On each of the first `V_LINES` lines, the block reads one line of the frame buffer. The line is `H_PIXELS/8` bytes long and begins at byte address `line * H_PIXELS/8`. The block issues the reads on a valid/ready request channel and keeps the returned bytes in a line buffer. At a fixed `VIDEO_START` clocks after line start, it shifts the bits out most significant first, one pixel every `PIX_DIV` clocks. The output is a 2-bit level code for an external resistor DAC. With the defaults (10 MHz clock) a line lasts 63.5 µs, the sync pulse is 4.7 µs, video starts at 7 µs, and pixels leave at 5 Mb/s across a 256 x 200 raster.

The back-pressure rules are as follows. The request channel holds `fb_req_valid_o` and the address steady until `fb_req_ready_i` is seen high at a clock edge. The read side must return bytes in request order on `fb_rsp_valid_i`, with no ready of its own, and each line's responses must arrive before that line ends. A byte that has not arrived when its pixels are due is shown as black.

Top module: `cvid_line_timer`

## Requirements
- R1: While `rst_i` is high, `level_o` is black (2'b01) and `fb_req_valid_o` is low.
- R2: A line lasts exactly `LINE_CLKS` clocks and a frame exactly `FRAME_LINES` lines. `level_o` lags the internal line position by one clock.
- R3: On a line outside the vertical-sync run, `level_o` is sync (2'b00) for the first `SYNC_CLKS` clocks of the line.
- R4: On lines `VS_FIRST` to `VS_FIRST+VS_COUNT-1`, `level_o` is sync for the first `LINE_CLKS-VS_GAP` clocks and black for the remaining clocks of the line.
- R5: On lines below `V_LINES`, pixel n (0 to `H_PIXELS-1`) occupies line clocks `VIDEO_START+n*PIX_DIV` to `VIDEO_START+(n+1)*PIX_DIV-1`. Pixel n is bit `7-(n%8)` of byte `n/8`. A set bit gives white (2'b11) and a clear bit gives black.
- R6: Outside sync and outside the pixel window, and on every line at or above `V_LINES`, `level_o` is black.
- R7: On a line v below `V_LINES`, the block requests addresses `v*H_PIXELS/8` upward in order, one per handshake, and never more than `H_PIXELS/8` of them. No request is made on the last clock of a line or on lines at or above `V_LINES`.
- R8: When a request is not accepted, `fb_req_valid_o` stays high and `fb_req_addr_o` stays unchanged on the next clock.
- R9: Pixels of a byte whose response has not yet been captured are black. Once the byte is captured, later pixels follow R5.
- R10: The code 2'b10 never appears on `level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per `LINE_CLKS` fraction of a line |
| rst_i | input | 1 | Synchronous active-high reset |
| fb_req_valid_o | output | 1 | Frame-buffer read request valid |
| fb_req_ready_i | input | 1 | Frame-buffer read request accepted |
| fb_req_addr_o | output | $clog2(V_LINES*H_PIXELS/8) | Byte address of the request |
| fb_rsp_valid_i | input | 1 | Returned byte valid, in request order |
| fb_rsp_data_i | input | 8 | Returned byte, leftmost pixel in bit 7 |
| level_o | output | 2 | Level code: 00 sync, 01 black, 11 white |

## Verification
A wrong horizontal or vertical count moves sync edges and pixel windows. This shows on `level_o` as soon as the next sync edge or window boundary should have occurred, which is at most one line later. A wrong line-kind decision changes the sync width during the very line it governs. A fetch index that slips shows up at the first request of the line as a wrong address. A line-buffer fault shows up as wrong white/black pixels within the same line's window. Those pixels are compared against a model that records every byte actually delivered, including bytes held back by a stalled ready.

// File: rtl/cvid_pkg.sv
package cvid_pkg;
  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b11
  } level_e;

  typedef enum logic {
    LINE_NORMAL = 1'b0,
    LINE_VSYNC  = 1'b1
  } line_kind_e;
endpackage

// File: rtl/cvid_raster.sv
module cvid_raster
  import cvid_pkg::*;
#(
  parameter int LINE_CLKS   = 635,
  parameter int FRAME_LINES = 262,
  parameter int V_LINES     = 200,
  parameter int VS_FIRST    = 240,
  parameter int VS_COUNT    = 3,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output line_kind_e    kind_o,
  output logic          new_line_o,
  output logic          active_o
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

  logic [VW-1:0] v_next;
  line_kind_e    kind_next;

  assign new_line_o = (h_o == H_LAST);
  assign active_o   = (int'(v_o) < V_LINES);

  always_comb begin
    v_next    = (v_o == V_LAST) ? '0 : v_o + 1'b1;
    kind_next = ((int'(v_next) >= VS_FIRST) && (int'(v_next) < VS_FIRST + VS_COUNT))
                ? LINE_VSYNC : LINE_NORMAL;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      h_o    <= '0;
      v_o    <= '0;
      kind_o <= (VS_FIRST == 0) ? LINE_VSYNC : LINE_NORMAL;
    end else if (new_line_o) begin
      h_o    <= '0;
      v_o    <= v_next;
      kind_o <= kind_next;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end

  AST_H_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    new_line_o |=> (h_o == '0)); // R2
  AST_V_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (new_line_o && v_o == V_LAST) |=> (v_o == '0)); // R2
  AST_VSYNC_KIND: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_o == LINE_VSYNC) |-> ((int'(v_o) >= VS_FIRST) && (int'(v_o) < VS_FIRST + VS_COUNT))); // R4
endmodule

// File: rtl/cvid_fetch.sv
module cvid_fetch #(
  parameter int H_PIXELS = 256,
  parameter int V_LINES  = 200,
  parameter int VW       = 9,
  localparam int BYTES = H_PIXELS / 8,
  localparam int BIW   = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int CW    = $clog2(BYTES + 1),
  localparam int AW    = $clog2(V_LINES * BYTES)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [VW-1:0]  v_i,
  input  logic           new_line_i,
  input  logic           active_i,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [AW-1:0]  req_addr_o,
  input  logic           rsp_valid_i,
  input  logic [7:0]     rsp_data_i,
  input  logic [BIW-1:0] rd_idx_i,
  output logic [7:0]     rd_byte_o,
  output logic           rd_ok_o
);
  logic          armed;
  logic [CW-1:0] req_cnt;
  logic [CW-1:0] rsp_cnt;
  logic [7:0]    lbuf [BYTES];
  logic [BYTES-1:0] lvalid;

  assign req_valid_o = armed && active_i && !new_line_i && (int'(req_cnt) < BYTES);
  assign req_addr_o  = AW'(int'(v_i) * BYTES + int'(req_cnt));
  assign rd_byte_o   = lbuf[rd_idx_i];
  assign rd_ok_o     = lvalid[rd_idx_i];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed   <= 1'b0;
      req_cnt <= '0;
      rsp_cnt <= '0;
      lvalid  <= '0;
    end else begin
      armed <= 1'b1;
      if (new_line_i) begin
        req_cnt <= '0;
        rsp_cnt <= '0;
        lvalid  <= '0;
      end else begin
        if (req_valid_o && req_ready_i) req_cnt <= req_cnt + 1'b1;
        if (rsp_valid_i && (int'(rsp_cnt) < BYTES)) begin
          lvalid[BIW'(rsp_cnt)] <= 1'b1;
          rsp_cnt <= rsp_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_i && !new_line_i && rsp_valid_i && (int'(rsp_cnt) < BYTES))
      lbuf[BIW'(rsp_cnt)] <= rsp_data_i;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R8
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_cnt <= req_cnt)); // R7
endmodule

// File: rtl/cvid_serializer.sv
module cvid_serializer
  import cvid_pkg::*;
#(
  parameter int LINE_CLKS   = 635,
  parameter int H_PIXELS    = 256,
  parameter int PIX_DIV     = 2,
  parameter int VIDEO_START = 70,
  parameter int SYNC_CLKS   = 47,
  parameter int VS_GAP      = 47,
  localparam int HW  = $clog2(LINE_CLKS),
  localparam int BYTES = H_PIXELS / 8,
  localparam int BIW = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int PXW = $clog2(H_PIXELS),
  localparam int WIN_END = VIDEO_START + H_PIXELS * PIX_DIV
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [HW-1:0]  h_i,
  input  line_kind_e     kind_i,
  input  logic           active_i,
  input  logic           new_line_i,
  output logic [BIW-1:0] rd_idx_o,
  input  logic [7:0]     rd_byte_i,
  input  logic           rd_ok_i,
  output logic [1:0]     level_o
);
  logic           sync_now;
  logic           in_win;
  logic [PXW-1:0] pix;
  logic           bit_val;
  level_e         level_d;

  always_comb begin
    sync_now = (kind_i == LINE_VSYNC) ? (int'(h_i) < LINE_CLKS - VS_GAP)
                                      : (int'(h_i) < SYNC_CLKS);
    in_win   = active_i && (int'(h_i) >= VIDEO_START) && (int'(h_i) < WIN_END);
    pix      = PXW'((int'(h_i) - VIDEO_START) / PIX_DIV);
    rd_idx_o = BIW'(pix >> 3);
    bit_val  = rd_byte_i[3'd7 - pix[2:0]];
    if (sync_now)                          level_d = LVL_SYNC;
    else if (in_win && rd_ok_i && bit_val) level_d = LVL_WHITE;
    else                                   level_d = LVL_BLACK;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) level_o <= LVL_BLACK;
    else       level_o <= level_d;
  end

  always_comb begin
    AST_NO_BAD_CODE: assert (rst_i || level_o != 2'b10); // R10
  end
  AST_LINE_OPENS_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(new_line_i, 2) |-> (level_o == LVL_SYNC)); // R3
  AST_WHITE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o == LVL_WHITE) |-> $past(in_win)); // R5
endmodule

// File: rtl/cvid_line_timer.sv
module cvid_line_timer
  import cvid_pkg::*;
#(
  parameter int LINE_CLKS   = 635,
  parameter int FRAME_LINES = 262,
  parameter int V_LINES     = 200,
  parameter int H_PIXELS    = 256,
  parameter int PIX_DIV     = 2,
  parameter int VIDEO_START = 70,
  parameter int SYNC_CLKS   = 47,
  parameter int VS_FIRST    = 240,
  parameter int VS_COUNT    = 3,
  parameter int VS_GAP      = 47,
  localparam int HW    = $clog2(LINE_CLKS),
  localparam int VW    = $clog2(FRAME_LINES),
  localparam int BYTES = H_PIXELS / 8,
  localparam int BIW   = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int AW    = $clog2(V_LINES * BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic          fb_req_valid_o,
  input  logic          fb_req_ready_i,
  output logic [AW-1:0] fb_req_addr_o,
  input  logic          fb_rsp_valid_i,
  input  logic [7:0]    fb_rsp_data_i,
  output logic [1:0]    level_o
);
  logic [HW-1:0]  h;
  logic [VW-1:0]  v;
  line_kind_e     kind;
  logic           new_line;
  logic           active;
  logic [BIW-1:0] rd_idx;
  logic [7:0]     rd_byte;
  logic           rd_ok;

  cvid_raster #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .V_LINES(V_LINES),
    .VS_FIRST(VS_FIRST), .VS_COUNT(VS_COUNT)
  ) u_raster (
    .clk_i(clk_i), .rst_i(rst_i), .h_o(h), .v_o(v), .kind_o(kind),
    .new_line_o(new_line), .active_o(active)
  );

  cvid_fetch #(
    .H_PIXELS(H_PIXELS), .V_LINES(V_LINES), .VW(VW)
  ) u_fetch (
    .clk_i(clk_i), .rst_i(rst_i), .v_i(v), .new_line_i(new_line), .active_i(active),
    .req_valid_o(fb_req_valid_o), .req_ready_i(fb_req_ready_i), .req_addr_o(fb_req_addr_o),
    .rsp_valid_i(fb_rsp_valid_i), .rsp_data_i(fb_rsp_data_i),
    .rd_idx_i(rd_idx), .rd_byte_o(rd_byte), .rd_ok_o(rd_ok)
  );

  cvid_serializer #(
    .LINE_CLKS(LINE_CLKS), .H_PIXELS(H_PIXELS), .PIX_DIV(PIX_DIV),
    .VIDEO_START(VIDEO_START), .SYNC_CLKS(SYNC_CLKS), .VS_GAP(VS_GAP)
  ) u_ser (
    .clk_i(clk_i), .rst_i(rst_i), .h_i(h), .kind_i(kind), .active_i(active),
    .new_line_i(new_line), .rd_idx_o(rd_idx), .rd_byte_i(rd_byte), .rd_ok_i(rd_ok),
    .level_o(level_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!fb_req_valid_o && level_o == LVL_BLACK)); // R1
endmodule

// File: tb/cvid_line_timer_bench.sv
module cvid_line_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CLKS = 60, FRAME_LINES = 12, V_LINES = 5, H_PIXELS = 16;
  localparam int PIX_DIV = 2, VIDEO_START = 14, SYNC_CLKS = 5;
  localparam int VS_FIRST = 8, VS_COUNT = 3, VS_GAP = 6;
  localparam int BYTES = H_PIXELS / 8;
  localparam int AW = $clog2(V_LINES * BYTES);
  localparam int RUN_CYCLES = 2 * LINE_CLKS * FRAME_LINES + 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [AW-1:0] req_addr;
  logic [7:0] rsp_data = 8'h00;
  logic [1:0] level;

  int vectors = 0, fails = 0;
  int hm = 0, vm = 0, frame = 0, mreq = 0, mrsp = 0, cyc = 0;
  logic [7:0] mbuf [BYTES];
  bit mvalid [BYTES];
  logic [1:0] exp_level = 2'b01;
  string exp_req = "R1";
  bit pend = 0;
  logic [7:0] pend_data = 8'h00;
  bit prev_stall = 0;
  logic [AW-1:0] prev_addr = '0;
  bit done = 0;

  cvid_line_timer #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .V_LINES(V_LINES),
    .H_PIXELS(H_PIXELS), .PIX_DIV(PIX_DIV), .VIDEO_START(VIDEO_START),
    .SYNC_CLKS(SYNC_CLKS), .VS_FIRST(VS_FIRST), .VS_COUNT(VS_COUNT), .VS_GAP(VS_GAP)
  ) u_cvid_line_timer (
    .clk_i(clk), .rst_i(rst), .fb_req_valid_o(req_valid), .fb_req_ready_i(req_ready),
    .fb_req_addr_o(req_addr), .fb_rsp_valid_i(rsp_valid), .fb_rsp_data_i(rsp_data),
    .level_o(level)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 91 + 23) ^ 8'hA6);
  endfunction

  // Reference model: advances on every clock edge, from bench-side signals only.
  always @(posedge clk) begin
    if (rst) begin
      exp_level = 2'b01; exp_req = "R1";
      hm = 0; vm = 0; mreq = 0; mrsp = 0;
      for (int i = 0; i < BYTES; i++) mvalid[i] = 0;
    end else begin
      bit vs;
      vs = (vm >= VS_FIRST) && (vm < VS_FIRST + VS_COUNT);
      if (vs) begin
        exp_level = (hm < LINE_CLKS - VS_GAP) ? 2'b00 : 2'b01; exp_req = "R4";
      end else if (hm < SYNC_CLKS) begin
        exp_level = 2'b00; exp_req = (hm == 0) ? "R2 R3" : "R3";
      end else if (vm < V_LINES && hm >= VIDEO_START && hm < VIDEO_START + H_PIXELS * PIX_DIV) begin
        int p;
        p = (hm - VIDEO_START) / PIX_DIV;
        exp_level = (mvalid[p / 8] && mbuf[p / 8][7 - (p % 8)]) ? 2'b11 : 2'b01;
        exp_req = mvalid[p / 8] ? "R5" : "R9";
      end else begin
        exp_level = 2'b01; exp_req = "R6";
      end
      if (hm == LINE_CLKS - 1) begin
        hm = 0; mreq = 0; mrsp = 0;
        for (int i = 0; i < BYTES; i++) mvalid[i] = 0;
        if (vm == FRAME_LINES - 1) begin vm = 0; frame++; end else vm++;
      end else begin
        hm++;
        if (rsp_valid && mrsp < BYTES) begin
          mbuf[mrsp] = rsp_data; mvalid[mrsp] = 1; mrsp++;
        end
      end
    end
  end

  task automatic fail_line(string req, int act, int expv);
    fails++;
    $display("FAIL %s actual=%0h expected=%0h (line %0d clk %0d)", req, act, expv, vm, hm);
  endtask

  initial begin : watchdog
    repeat (RUN_CYCLES * 4) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, RUN_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(negedge clk);
      cyc = c;
      if (c == 4) rst = 1'b0;
      // level compare (R1 during reset, then R2..R6, R9 by position)
      vectors++;
      if (level !== exp_level) fail_line(exp_req, level, exp_level);
      vectors++;
      if (level === 2'b10) fail_line("R10", level, 1);
      if (rst) begin
        vectors++;
        if (req_valid !== 1'b0) fail_line("R1", req_valid, 0);
      end
      // R8: stalled request stays posted with the same address
      if (prev_stall) begin
        vectors++;
        if (req_valid !== 1'b1 || req_addr !== prev_addr) fail_line("R8", req_addr, prev_addr);
      end
      // respond to last cycle's handshake, then drive ready for the coming edge
      rsp_valid = pend; rsp_data = pend_data; pend = 0;
      req_ready = (frame == 0 && vm == 2 && hm < 32) ? 1'b0 : ((c % 3) != 0);
      #1;
      if (req_valid === 1'b1) begin
        vectors++;
        if (vm >= V_LINES || mreq >= BYTES || hm == LINE_CLKS - 1)
          fail_line("R7", req_valid, 0);
        else if (int'(req_addr) != vm * BYTES + mreq)
          fail_line("R7", req_addr, vm * BYTES + mreq);
        if (req_ready) begin
          pend = 1; pend_data = mem_byte(int'(req_addr)); mreq++;
        end
      end
      prev_stall = (req_valid === 1'b1) && !req_ready;
      prev_addr = req_addr;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule